// File: doc/BRIEF.md
# Bank Clock Divider Set

This block turns one fast internal clock into three banks of four divided clocks (banks A, B and C) and a single feedback clock. Every bank has its own divide-ratio select code, so the three banks and the feedback output can all run at different frequencies. An optional divide-by-two stage sits ahead of every divider, and a bypass mode swaps the fast clock for the reference clock so the dividers can be exercised without the oscillator.

Each stoppable output takes an enable bit from an external stop register. A stopped output stays low, and a stop or a restart only takes effect while that output is low, so no shortened pulse ever appears. The two upper bank-C outputs can be inverted by half a period. An active-low master reset clears every divider, forces the outputs low and withdraws the pad drive enable. All dividers then rise together on the first division-clock edge after reset is released.

Top module: `bank_clkdiv_top`

## Requirements
- R1: Bank A select code 00, 01, 10, 11 gives an output period of 4, 6, 8, 12 division-clock cycles.
- R2: Bank B select code 00, 01, 10, 11 gives an output period of 4, 6, 8, 10 division-clock cycles.
- R3: Bank C select code 00, 01, 10, 11 gives an output period of 2, 4, 6, 8 division-clock cycles.
- R4: The 3-bit feedback select code 000 to 111 gives a feedback period of 4, 6, 8, 10, 8, 12, 16, 20 division-clock cycles, so codes 010 and 100 give the same ratio.
- R5: With vco_div1_i low, the division clock is the source clock divided by two; with it high, the division clock is the source clock.
- R6: With pll_on_i low (bypass), ref_clk_i replaces fast_clk_i as the source clock.
- R7: Every output is high for exactly half of its period.
- R8: After reset is released, all non-inverted outputs go high on the same division-clock edge.
- R9: With inv_c_i high, qc_o[2] and qc_o[3] are the complement of qc_o[0] and qc_o[1]; with it low, all four bank-C outputs are equal.
- R10: While rst_ni is low, every clock output is low and drv_en_o is low; drv_en_o is high when rst_ni is high.
- R11: An output whose enable bit is 0 stays low while the others keep toggling. The enable bits map as en_a_i[i] to qa_o[i], en_b_i[i] to qb_o[i], and en_c_i[j] to qc_o[j+1]. qc_o[0] and qfb_o have no enable bit.
- R12: A stop or restart takes effect only while the output is low, so every high pulse keeps its full half-period width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fast_clk_i | input | 1 | Fast internal clock (oscillator stand-in) |
| ref_clk_i | input | 1 | Reference clock used in bypass mode |
| rst_ni | input | 1 | Active-low master reset and output enable |
| pll_on_i | input | 1 | 1: fast clock is the source; 0: bypass, reference is the source |
| vco_div1_i | input | 1 | 1: no pre-divide; 0: source divided by two |
| sel_a_i | input | 2 | Bank A ratio code |
| sel_b_i | input | 2 | Bank B ratio code |
| sel_c_i | input | 2 | Bank C ratio code |
| sel_fb_i | input | 3 | Feedback ratio code |
| inv_c_i | input | 1 | Invert qc_o[2] and qc_o[3] |
| en_a_i | input | 4 | Per-output enables for bank A |
| en_b_i | input | 4 | Per-output enables for bank B |
| en_c_i | input | 3 | Enables for qc_o[1] to qc_o[3] |
| qa_o | output | 4 | Bank A clocks |
| qb_o | output | 4 | Bank B clocks |
| qc_o | output | 4 | Bank C clocks |
| qfb_o | output | 1 | Feedback clock |
| drv_en_o | output | 1 | Pad drive enable, low means tri-state |

## Verification
Every output register updates on a rising division-clock edge, so the first high level after reset release shows at the next fast-clock falling edge after the first division edge. That edge is one fast cycle late with pre-divide, and up to one reference period late in bypass. The bench samples only at fast-clock falling edges and expresses every period and high time in those samples: the ratio, times two when pre-divide is on, times four in bypass, where the reference runs at a quarter of the fast rate. An enable change is due within one output period, so the bench waits a full period before it checks that a stopped output holds low. Throughout the stop and restart sequence, a pulse monitor measures the width of every high pulse.

// File: rtl/bcd_pkg.sv
package bcd_pkg;
  localparam int unsigned CNT_W = 5;

  typedef enum logic [1:0] {KIND_A, KIND_B, KIND_C, KIND_FB} bank_kind_e;

  function automatic logic [CNT_W-1:0] ratio_of(bank_kind_e kind, logic [2:0] sel);
    logic [CNT_W-1:0] r;
    r = 5'd4;
    case (kind)
      KIND_A: begin
        case (sel[1:0])
          2'd0: r = 5'd4;
          2'd1: r = 5'd6;
          2'd2: r = 5'd8;
          default: r = 5'd12;
        endcase
      end
      KIND_B: begin
        case (sel[1:0])
          2'd0: r = 5'd4;
          2'd1: r = 5'd6;
          2'd2: r = 5'd8;
          default: r = 5'd10;
        endcase
      end
      KIND_C: begin
        case (sel[1:0])
          2'd0: r = 5'd2;
          2'd1: r = 5'd4;
          2'd2: r = 5'd6;
          default: r = 5'd8;
        endcase
      end
      default: begin
        case (sel)
          3'd0: r = 5'd4;
          3'd1: r = 5'd6;
          3'd2: r = 5'd8;
          3'd3: r = 5'd10;
          3'd4: r = 5'd8;
          3'd5: r = 5'd12;
          3'd6: r = 5'd16;
          default: r = 5'd20;
        endcase
      end
    endcase
    return r;
  endfunction
endpackage

// File: rtl/clk_src.sv
module clk_src (
  input  logic fast_clk_i,
  input  logic ref_clk_i,
  input  logic rst_ni,
  input  logic pll_on_i,
  input  logic div1_i,
  output logic div_clk_o
);
  logic src_clk;
  logic half_q;

  assign src_clk = pll_on_i ? fast_clk_i : ref_clk_i;

  always_ff @(posedge src_clk or negedge rst_ni) begin
    if (!rst_ni) half_q <= 1'b0;
    else         half_q <= ~half_q;
  end

  assign div_clk_o = div1_i ? src_clk : half_q;

  // R5: the pre-divide flop alternates on every source edge
  assert_half_rise_R5: assert property (@(posedge src_clk) disable iff (!rst_ni)
    !half_q |=> half_q) else $error("pre-divide stuck low");
  assert_half_fall_R5: assert property (@(posedge src_clk) disable iff (!rst_ni)
    half_q |=> !half_q) else $error("pre-divide stuck high");
endmodule

// File: rtl/out_gate.sv
module out_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic base_i,
  input  logic inv_i,
  input  logic en_i,
  output logic q_o
);
  logic pol_next;
  logic en_q;
  logic q_q;

  assign pol_next = base_i ^ inv_i;

  // enable only reloads during a low phase of the output
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= 1'b1;
      q_q  <= 1'b0;
    end else begin
      if (!pol_next) en_q <= en_i;
      q_q <= pol_next & en_q;
    end
  end

  assign q_o = q_q;

  assert_no_runt_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(en_q) |-> !q_q) else $error("enable moved during high phase");
  assert_stopped_low_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(q_q) |-> en_q) else $error("stopped output rose");
endmodule

// File: rtl/bank_div.sv
module bank_div
  import bcd_pkg::*;
#(
  parameter bank_kind_e           KIND     = KIND_A,
  parameter int unsigned          SEL_W    = 2,
  parameter int unsigned          NUM_OUT  = 4,
  parameter logic [NUM_OUT-1:0]   INV_MASK = '0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [SEL_W-1:0]   sel_i,
  input  logic               inv_i,
  input  logic [NUM_OUT-1:0] en_i,
  output logic [NUM_OUT-1:0] q_o
);
  logic [2:0]       sel_ext;
  logic [CNT_W-1:0] ratio;
  logic [CNT_W-1:0] half;
  logic [CNT_W-1:0] cnt_q;
  logic             base_next;

  assign sel_ext   = 3'(sel_i);
  assign ratio     = ratio_of(KIND, sel_ext);
  assign half      = ratio >> 1;
  assign base_next = (cnt_q < half);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (cnt_q >= ratio - 5'd1) cnt_q <= '0;
    else                           cnt_q <= cnt_q + 5'd1;
  end

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_out
    out_gate u_gate (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .base_i (base_next),
      .inv_i  (INV_MASK[g] & inv_i),
      .en_i   (en_i[g]),
      .q_o    (q_o[g])
    );
  end

  // R1 R2 R3 R4: the phase counter stays inside the selected ratio
  assert_cnt_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($stable(sel_i) && ($past(cnt_q) < ratio)) |-> (cnt_q < ratio))
    else $error("phase counter left its ratio");
endmodule

// File: rtl/bank_clkdiv_top.sv
module bank_clkdiv_top
  import bcd_pkg::*;
#(
  parameter int unsigned BANK_W   = 4,
  parameter int unsigned BSEL_W   = 2,
  parameter int unsigned FSEL_W   = 3,
  parameter logic [BANK_W-1:0] C_INV_MASK = 4'b1100
) (
  input  logic              fast_clk_i,
  input  logic              ref_clk_i,
  input  logic              rst_ni,
  input  logic              pll_on_i,
  input  logic              vco_div1_i,
  input  logic [BSEL_W-1:0] sel_a_i,
  input  logic [BSEL_W-1:0] sel_b_i,
  input  logic [BSEL_W-1:0] sel_c_i,
  input  logic [FSEL_W-1:0] sel_fb_i,
  input  logic              inv_c_i,
  input  logic [BANK_W-1:0] en_a_i,
  input  logic [BANK_W-1:0] en_b_i,
  input  logic [BANK_W-2:0] en_c_i,
  output logic [BANK_W-1:0] qa_o,
  output logic [BANK_W-1:0] qb_o,
  output logic [BANK_W-1:0] qc_o,
  output logic              qfb_o,
  output logic              drv_en_o
);
  logic div_clk;

  clk_src u_src (
    .fast_clk_i (fast_clk_i),
    .ref_clk_i  (ref_clk_i),
    .rst_ni     (rst_ni),
    .pll_on_i   (pll_on_i),
    .div1_i     (vco_div1_i),
    .div_clk_o  (div_clk)
  );

  bank_div #(.KIND(KIND_A), .SEL_W(BSEL_W), .NUM_OUT(BANK_W), .INV_MASK('0)) u_bank_a (
    .clk_i (div_clk), .rst_ni (rst_ni), .sel_i (sel_a_i), .inv_i (1'b0),
    .en_i (en_a_i), .q_o (qa_o)
  );

  bank_div #(.KIND(KIND_B), .SEL_W(BSEL_W), .NUM_OUT(BANK_W), .INV_MASK('0)) u_bank_b (
    .clk_i (div_clk), .rst_ni (rst_ni), .sel_i (sel_b_i), .inv_i (1'b0),
    .en_i (en_b_i), .q_o (qb_o)
  );

  // qc_o[0] is never stopped
  bank_div #(.KIND(KIND_C), .SEL_W(BSEL_W), .NUM_OUT(BANK_W), .INV_MASK(C_INV_MASK)) u_bank_c (
    .clk_i (div_clk), .rst_ni (rst_ni), .sel_i (sel_c_i), .inv_i (inv_c_i),
    .en_i ({en_c_i, 1'b1}), .q_o (qc_o)
  );

  bank_div #(.KIND(KIND_FB), .SEL_W(FSEL_W), .NUM_OUT(1), .INV_MASK(1'b0)) u_bank_fb (
    .clk_i (div_clk), .rst_ni (rst_ni), .sel_i (sel_fb_i), .inv_i (1'b0),
    .en_i (1'b1), .q_o (qfb_o)
  );

  assign drv_en_o = rst_ni;

  // R8: bank A and feedback start together after reset
  assert_aligned_start_R8: assert property (@(posedge div_clk) disable iff (!rst_ni)
    ($rose(qfb_o) && $past(qfb_o) == 1'b0 && $past(qa_o[0]) == 1'b0
     && $past(en_a_i[0]) && $past(sel_fb_i) == 3'd0 && $past(sel_a_i) == 2'd0
     && $stable(sel_fb_i) && $stable(sel_a_i)) |-> qa_o[0])
    else $error("bank A and feedback out of step");
endmodule

// File: tb/bank_clkdiv_top_tb.sv
module bank_clkdiv_top_tb;
  logic fast_clk = 1'b0;
  logic ref_clk  = 1'b0;
  logic rst_n    = 1'b0;
  logic pll_on   = 1'b1;
  logic vco_div1 = 1'b1;
  logic [1:0] sel_a = '0, sel_b = '0, sel_c = '0;
  logic [2:0] sel_fb = '0;
  logic inv_c = 1'b0;
  logic [3:0] en_a = '1, en_b = '1;
  logic [2:0] en_c = '1;
  logic [3:0] qa, qb, qc;
  logic qfb, drv_en;
  logic [12:0] all_w;

  int nchk = 0, nerr = 0, cyc = 0;
  bit mon_on = 1'b0;
  int exp_half [13];
  int run_len [13];

  bank_clkdiv_top u_dut (
    .fast_clk_i (fast_clk), .ref_clk_i (ref_clk), .rst_ni (rst_n),
    .pll_on_i (pll_on), .vco_div1_i (vco_div1),
    .sel_a_i (sel_a), .sel_b_i (sel_b), .sel_c_i (sel_c), .sel_fb_i (sel_fb),
    .inv_c_i (inv_c), .en_a_i (en_a), .en_b_i (en_b), .en_c_i (en_c),
    .qa_o (qa), .qb_o (qb), .qc_o (qc), .qfb_o (qfb), .drv_en_o (drv_en)
  );

  assign all_w = {qfb, qc, qb, qa};

  // 125 MHz fast clock; reference at a quarter rate, rising with fast clock
  initial forever #4 fast_clk = ~fast_clk;
  initial begin
    #4 ref_clk = 1'b1;
    forever begin #16 ref_clk = 1'b0; #16 ref_clk = 1'b1; end
  end

  function automatic int ra(int c); int t [4] = '{4, 6, 8, 12}; return t[c]; endfunction
  function automatic int rb(int c); int t [4] = '{4, 6, 8, 10}; return t[c]; endfunction
  function automatic int rc(int c); int t [4] = '{2, 4, 6, 8}; return t[c]; endfunction
  function automatic int rf(int c); int t [8] = '{4, 6, 8, 10, 8, 12, 16, 20}; return t[c]; endfunction

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge fast_clk);
      cyc++;
      if (cyc > 150000) begin
        nerr++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        finish_run();
      end
    end
  end

  // pulse-width monitor for R12 / R7
  always @(negedge fast_clk) begin
    for (int i = 0; i < 13; i++) begin
      if (!mon_on) run_len[i] = 0;
      else if (all_w[i]) run_len[i]++;
      else if (run_len[i] != 0) begin
        nchk++;
        if (run_len[i] != exp_half[i]) begin
          nerr++;
          $display("FAIL R12 pulse out%0d actual=%0d expected=%0d", i, run_len[i], exp_half[i]);
        end
        run_len[i] = 0;
      end
    end
  end

  task automatic measure(input int idx, output int hi, output int per);
    logic prev;
    prev = all_w[idx];
    forever begin
      @(negedge fast_clk);
      if (!prev && all_w[idx]) break;
      prev = all_w[idx];
    end
    hi = 0; per = 0;
    while (all_w[idx]) begin hi++; per++; @(negedge fast_clk); end
    while (!all_w[idx]) begin per++; @(negedge fast_clk); end
  endtask

  // reset, apply configuration, release, check R10 and R8
  task automatic apply(input logic d1, input logic pl, input int k, input logic iv);
    int w;
    logic [12:0] exp_first;
    @(negedge fast_clk);
    rst_n = 1'b0;
    vco_div1 = d1; pll_on = pl;
    sel_a = 2'(k % 4); sel_b = 2'(k % 4); sel_c = 2'(k % 4); sel_fb = 3'(k);
    inv_c = iv; en_a = '1; en_b = '1; en_c = '1;
    repeat (6) @(negedge fast_clk);
    chk("R10 drv_en in reset", int'(drv_en), 0);
    chk("R10 outputs in reset", int'(all_w), 0);
    rst_n = 1'b1;
    @(negedge fast_clk);
    chk("R10 drv_en after release", int'(drv_en), 1);
    w = 0;
    while (all_w == '0 && w < 400) begin @(negedge fast_clk); w++; end
    exp_first = iv ? 13'h13ff : 13'h1fff;
    chk("R8 first rise aligned", int'(all_w), int'(exp_first));
  endtask

  initial begin
    int hi, per, m, rises;
    logic bad, prev;
    // R1 R2 R3 R4 R5 R6 R7: sweep ratio codes over source modes
    for (int mode = 0; mode < 4; mode++) begin
      for (int k = 0; k < 8; k++) begin
        logic d1, pl;
        if (mode == 3 && !(k == 0 || k == 7)) continue;
        d1 = (mode == 0 || mode == 2);
        pl = (mode < 2);
        m = (d1 ? 1 : 2) * (pl ? 1 : 4);
        apply(d1, pl, k, 1'b0);
        measure(0, hi, per);
        chk($sformatf("R1 A code%0d mode%0d period", k % 4, mode), per, ra(k % 4) * m);
        chk("R7 A duty", hi * 2, per);
        measure(4, hi, per);
        chk($sformatf("R2 B code%0d mode%0d period", k % 4, mode), per, rb(k % 4) * m);
        chk("R7 B duty", hi * 2, per);
        measure(8, hi, per);
        chk($sformatf("R3 C code%0d mode%0d period", k % 4, mode), per, rc(k % 4) * m);
        chk("R7 C duty", hi * 2, per);
        measure(12, hi, per);
        chk($sformatf("R4 FB code%0d mode%0d period", k, mode), per, rf(k) * m);
        chk("R7 FB duty", hi * 2, per);
        if (mode == 1) chk("R5 pre-divide doubles FB", per, 2 * rf(k));
        if (mode == 2) chk("R6 bypass uses reference", per, 4 * rf(k));
      end
    end

    // R9: inversion of qc[2], qc[3]
    for (int iv = 0; iv < 2; iv++) begin
      apply(1'b1, 1'b1, 1, iv[0]);
      bad = 1'b0;
      repeat (40) begin
        @(negedge fast_clk);
        if (qc[1] != qc[0]) bad = 1'b1;
        if (qc[2] != (qc[0] ^ iv[0]) || qc[3] != (qc[0] ^ iv[0])) bad = 1'b1;
      end
      chk($sformatf("R9 bank C phase inv=%0d", iv), int'(bad), 0);
      measure(10, hi, per);
      chk("R9 inverted output period", per, 4);
      chk("R7 inverted output duty", hi * 2, per);
    end

    // R11 R12: stop and restart mid high phase
    apply(1'b1, 1'b1, 3, 1'b0);
    for (int i = 0; i < 13; i++) begin
      if (i < 4) exp_half[i] = ra(3) / 2;
      else if (i < 8) exp_half[i] = rb(3) / 2;
      else if (i < 12) exp_half[i] = rc(3) / 2;
      else exp_half[i] = rf(3) / 2;
    end
    mon_on = 1'b1;
    measure(1, hi, per);
    prev = qa[1];
    while (!qa[1]) @(negedge fast_clk);
    repeat (2) @(negedge fast_clk);
    en_a[1] = 1'b0; en_b[2] = 1'b0; en_c = 3'b000;
    repeat (30) @(negedge fast_clk);
    bad = 1'b0;
    rises = 0; prev = qc[0];
    repeat (40) begin
      @(negedge fast_clk);
      if (qa[1] || qb[2] || qc[1] || qc[2] || qc[3]) bad = 1'b1;
      if (!prev && qc[0]) rises++;
      prev = qc[0];
    end
    chk("R11 stopped outputs stay low", int'(bad), 0);
    chk("R11 qc0 keeps running", int'(rises >= 4), 1);
    measure(0, hi, per);
    chk("R11 qa0 keeps running", per, 12);
    measure(12, hi, per);
    chk("R11 qfb keeps running", per, 10);
    while (!qa[0]) @(negedge fast_clk);
    repeat (3) @(negedge fast_clk);
    en_a = '1; en_b = '1; en_c = '1;
    repeat (60) @(negedge fast_clk);
    measure(1, hi, per);
    chk("R12 qa1 restarts full width", hi, 6);
    measure(9, hi, per);
    chk("R12 qc1 restarts full period", per, 8);
    mon_on = 1'b0;
    @(negedge fast_clk);
    finish_run();
  end
endmodule